// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache with Line Flush

This block is a write-back data cache placed between a single core's request port and a next-level memory port. The core issues one operation at a time (load, store, or flush-line) with a byte address. The cache keeps a tag, a valid bit and a dirty bit for every line. The default geometry is 64-byte lines in 4 ways per set over 128 sets, which gives 32 KB. Loads and stores that hit are served from the resident line. A miss chooses a victim way, writes the victim back if it holds modified data, then fetches the whole line from the next level. After that the access completes in the freshly filled way.

A flush-line command removes the line that holds the given address. If the line is modified, it is copied back to the next level first. The timing has two phases: a single tag-compare cycle, then a data-array phase of `DATA_LAT` cycles. Operations that finish at the tag compare (a flush that misses, or a flush of a clean line) skip the data phase. The next-level port moves whole lines. It uses a request that is held until a one-cycle acknowledge.

Top module: `wb_line_cache`

## Requirements
- R1: While reset is asserted and after its release, `req_ready_o` is 1, `resp_valid_o` is 0 and `mem_req_o` is 0. Every line starts invalid, so the first access to any line misses.
- R2: A load (op 2'd0) that hits returns the 32-bit word chosen by address bits [5:2] of the line selected by the bits directly above bit 5. `resp_valid_o` rises in the cycle 2+`DATA_LAT` after the accept edge, and there is no memory traffic.
- R3: A load or store that misses issues exactly one line read at the line-aligned address (offset bits zero). The operation then completes with the data from that read.
- R4: A store (op 2'd1) writes its word into the resident line and marks the line dirty. A later eviction of that line writes the full line, store included, back to memory.
- R5: The victim is the lowest-numbered invalid way, or else the least recently used way. Load hits, store hits and line fills all make the touched way the most recent. After reset way 0 is the least recent.
- R6: A dirty victim is written back in full, and the write is acknowledged, before the fill read is requested. A clean victim causes no write.
- R7: A flush-line (op 2'd2) that hits a dirty line writes that line back and invalidates it. The next access to the line misses.
- R8: A flush-line that hits a clean line invalidates it with no memory traffic. It responds in cycle 2 after the accept edge.
- R9: A flush-line that misses responds in cycle 2 after the accept edge with no memory traffic.
- R10: `req_ready_o` is 0 from the accept edge until the response. `resp_valid_o` is a one-cycle pulse, and the port is ready again in the cycle after it.
- R11: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay unchanged from the start of a memory request until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_op_i | input | 2 | 0 load, 1 store, 2 flush-line |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | DATA_W | Store data |
| resp_valid_o | output | 1 | Operation complete (one cycle) |
| resp_rdata_o | output | DATA_W | Load data, valid with resp_valid_o |
| mem_req_o | output | 1 | Next-level request, held until ack |
| mem_we_o | output | 1 | 1 line write-back, 0 line read |
| mem_addr_o | output | ADDR_W | Line-aligned byte address |
| mem_wdata_o | output | LINE_BYTES*8 | Write-back line |
| mem_ack_i | input | 1 | Next-level completion pulse |
| mem_rdata_i | input | LINE_BYTES*8 | Fill line, valid with mem_ack_i |

## Verification
The embedded properties check, on every cycle, the handshake rules at both ports. These are: the busy window and response pulse, a memory request held steady until acknowledged, no traffic after a hit, a fill never landing on a dirty way, a dirty flush hit starting a write, and the immediate answer to a flush miss. They also check the internal invariants of at most one matching way and exactly one least-recent way per set. Only the bench scenarios can show that the data is right end to end, that the correct line is chosen as the victim after a given access history, and that modified data reaches memory through eviction and flush. The final sweep over every set with more lines than ways compares the whole backing memory with an arithmetic model.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FLUSH = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_TAG,
    S_WB,
    S_FILL,
    S_DATA,
    S_RESP
  } state_e;
endpackage

// File: rtl/wb_cache_tags.sv
module wb_cache_tags #(
  parameter int SETS  = 128,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic [WAYS-1:0]             hit_o,
  output logic [WAYS-1:0]             valid_o,
  output logic [WAYS-1:0]             dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]  tags_o,
  input  logic                        wr_en_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic                        wr_valid_i,
  input  logic                        wr_dirty_i
);
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  dirty_q [SETS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[idx_i][wr_way_i] <= wr_tag_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[idx_i][wr_way_i] <= wr_valid_i;
      dirty_q[idx_i][wr_way_i] <= wr_dirty_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign tags_o[w] = tag_q[idx_i][w];
    assign hit_o[w]  = valid_q[idx_i][w] && (tag_q[idx_i][w] == tag_i);
  end

  // R5: a block is resident in at most one way
  a_r5_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_o));
endmodule

// File: rtl/wb_cache_lru.sv
module wb_cache_lru #(
  parameter int SETS = 128,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             touch_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] lru_way_o
);
  // age 0 = most recent, WAYS-1 = least recent
  logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            is_old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[idx_i][w] <= '0;
        else if (age_q[idx_i][w] < age_q[idx_i][touch_way_i])
          age_q[idx_i][w] <= age_q[idx_i][w] + WAY_W'(1);
      end
    end
  end

  always_comb begin
    lru_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      is_old[w] = (age_q[idx_i][w] == WAY_W'(WAYS - 1));
      if (is_old[w]) lru_way_o = WAY_W'(w);
    end
  end

  // R5: the ages in a set stay a permutation, so one way is the oldest
  a_r5_one_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(is_old) == 1);
endmodule

// File: rtl/wb_cache_lines.sv
module wb_cache_lines #(
  parameter int SETS      = 128,
  parameter int WAYS      = 4,
  parameter int LINE_BITS = 512,
  parameter int DATA_W    = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int WSEL_W = $clog2(LINE_BITS / DATA_W)
) (
  input  logic                 clk_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [WAY_W-1:0]     way_i,
  output logic [LINE_BITS-1:0] line_o,
  input  logic                 line_we_i,
  input  logic [LINE_BITS-1:0] line_i,
  input  logic                 word_we_i,
  input  logic [WSEL_W-1:0]    word_sel_i,
  input  logic [DATA_W-1:0]    word_i
);
  logic [LINE_BITS-1:0] line_q [SETS*WAYS];
  logic [IDX_W+WAY_W-1:0] slot;

  assign slot   = {idx_i, way_i};
  assign line_o = line_q[slot];

  always_ff @(posedge clk_i) begin
    if (line_we_i)
      line_q[slot] <= line_i;
    else if (word_we_i)
      line_q[slot][word_sel_i*DATA_W +: DATA_W] <= word_i;
  end
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int WAYS       = 4,
  parameter int SETS       = 128,
  parameter int DATA_LAT   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [1:0]              req_op_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DATA_W-1:0]       req_wdata_i,
  output logic                    resp_valid_o,
  output logic [DATA_W-1:0]       resp_rdata_o,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [LINE_BYTES*8-1:0] mem_wdata_o,
  input  logic                    mem_ack_i,
  input  logic [LINE_BYTES*8-1:0] mem_rdata_i
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(SETS);
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
  localparam int WAY_W     = $clog2(WAYS);
  localparam int BYTE_W    = $clog2(DATA_W / 8);
  localparam int WSEL_W    = OFF_W - BYTE_W;
  localparam int CNT_W     = $clog2(DATA_LAT + 1);

  state_e              state_q, state_d;
  op_e                 op_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q, rdata_d;
  logic [WAY_W-1:0]    way_q, way_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [WSEL_W-1:0]   wsel;
  logic                unused_addr_lo;

  logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
  logic [WAYS-1:0][TAG_W-1:0] tags_vec;
  logic                       hit_any;
  logic [WAY_W-1:0]           hit_way, lru_way, victim;

  logic                 tag_we, tag_wvalid, tag_wdirty;
  logic [WAY_W-1:0]     tag_wway;
  logic                 line_we, word_we, lru_touch;
  logic [LINE_BITS-1:0] line_rd;

  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BYTE_W +: WSEL_W];
  assign unused_addr_lo = ^addr_q[BYTE_W-1:0];

  wb_cache_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .idx_i(idx), .tag_i(tag),
    .hit_o(hit_vec), .valid_o(valid_vec), .dirty_o(dirty_vec), .tags_o(tags_vec),
    .wr_en_i(tag_we), .wr_way_i(tag_wway), .wr_tag_i(tag),
    .wr_valid_i(tag_wvalid), .wr_dirty_i(tag_wdirty)
  );

  wb_cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i, .rst_ni,
    .idx_i(idx), .touch_i(lru_touch), .touch_way_i(way_q), .lru_way_o(lru_way)
  );

  wb_cache_lines #(.SETS(SETS), .WAYS(WAYS), .LINE_BITS(LINE_BITS), .DATA_W(DATA_W)) u_lines (
    .clk_i,
    .idx_i(idx), .way_i(way_q), .line_o(line_rd),
    .line_we_i(line_we), .line_i(mem_rdata_i),
    .word_we_i(word_we), .word_sel_i(wsel), .word_i(wdata_q)
  );

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // lowest invalid way first, else least recent
  always_comb begin
    victim = lru_way;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!valid_vec[w]) victim = WAY_W'(w);
  end

  always_comb begin
    state_d    = state_q;
    way_d      = way_q;
    cnt_d      = cnt_q;
    rdata_d    = rdata_q;
    tag_we     = 1'b0;
    tag_wway   = way_q;
    tag_wvalid = 1'b0;
    tag_wdirty = 1'b0;
    line_we    = 1'b0;
    word_we    = 1'b0;
    lru_touch  = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_valid_i) state_d = S_TAG;
      S_TAG: begin
        if (hit_any) begin
          way_d = hit_way;
          if (op_q == OP_FLUSH) begin
            if (dirty_vec[hit_way]) begin
              state_d = S_WB;
            end else begin
              tag_we   = 1'b1;
              tag_wway = hit_way;
              state_d  = S_RESP;
            end
          end else begin
            cnt_d   = '0;
            state_d = S_DATA;
          end
        end else if (op_q == OP_FLUSH) begin
          state_d = S_RESP;
        end else begin
          way_d   = victim;
          state_d = (valid_vec[victim] && dirty_vec[victim]) ? S_WB : S_FILL;
        end
      end
      S_WB: if (mem_ack_i) begin
        tag_we  = 1'b1;  // line leaves the cache once memory holds it
        state_d = (op_q == OP_FLUSH) ? S_RESP : S_FILL;
      end
      S_FILL: if (mem_ack_i) begin
        line_we    = 1'b1;
        tag_we     = 1'b1;
        tag_wvalid = 1'b1;
        lru_touch  = 1'b1;
        cnt_d      = '0;
        state_d    = S_DATA;
      end
      S_DATA: begin
        if (cnt_q == CNT_W'(DATA_LAT - 1)) begin
          lru_touch = 1'b1;
          if (op_q == OP_STORE) begin
            word_we    = 1'b1;
            tag_we     = 1'b1;
            tag_wvalid = 1'b1;
            tag_wdirty = 1'b1;
          end else begin
            rdata_d = line_rd[wsel*DATA_W +: DATA_W];
          end
          state_d = S_RESP;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      way_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      way_q   <= way_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      if (state_q == S_IDLE && req_valid_i) begin
        op_q    <= op_e'(req_op_i);
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o  = (state_q == S_IDLE);
  assign resp_valid_o = (state_q == S_RESP);
  assign resp_rdata_o = rdata_q;
  assign mem_req_o    = (state_q == S_WB) || (state_q == S_FILL);
  assign mem_we_o     = (state_q == S_WB);
  assign mem_addr_o   = (state_q == S_WB) ? {tags_vec[way_q], idx, {OFF_W{1'b0}}}
                                          : {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata_o  = line_rd;

  // R10: busy from accept until response, response is a single pulse
  a_r10_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  a_r10_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> (!resp_valid_o && req_ready_o));
  // R11: memory request held steady until acknowledged
  a_r11_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));
  // R2: a load or store hit generates no memory request
  a_r2_hit_no_traffic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAG && hit_any && op_q != OP_FLUSH) |=> !mem_req_o);
  // R6: a fill never overwrites a modified line
  a_r6_fill_clean_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL) |-> !(valid_vec[way_q] && dirty_vec[way_q]));
  // R7: a flush that hits a dirty line starts a write-back
  a_r7_dirty_flush_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAG && op_q == OP_FLUSH && hit_any && dirty_vec[hit_way])
      |=> (mem_req_o && mem_we_o));
  // R9: a flush miss answers right after the tag phase
  a_r9_flush_miss_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_TAG && op_q == OP_FLUSH && !hit_any) |=> (resp_valid_o && !mem_req_o));
endmodule

// File: tb/wb_line_cache_bench.sv
`timescale 1ns/1ps
module wb_line_cache_bench;
  localparam int ADDR_W = 14;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int LAT    = 3;
  localparam int LBITS  = 512;
  localparam int MEM_LAT = 3;
  localparam int NWORDS = (1 << ADDR_W) / 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0;
  logic req_ready_o;
  logic [1:0] req_op_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic resp_valid_o;
  logic [31:0] resp_rdata_o;
  logic mem_req_o, mem_we_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [LBITS-1:0] mem_wdata_o;
  logic mem_ack_i;
  logic [LBITS-1:0] mem_rdata_i;

  always #2 clk = ~clk;

  wb_line_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .DATA_LAT(LAT)) u_wb_line_cache (
    .clk_i(clk), .rst_ni,
    .req_valid_i, .req_ready_o, .req_op_i, .req_addr_i, .req_wdata_i,
    .resp_valid_o, .resp_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  logic [31:0] mem_w [NWORDS];
  logic [31:0] ref_w [NWORDS];
  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, proto_err = 0, busy_err = 0;
  logic [1:0] kind_hist = '0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // next-level memory model
  initial begin
    int cnt;
    logic [ADDR_W-1:0] held_a;
    logic held_we;
    int base;
    cnt = 0; held_a = '0; held_we = 1'b0;
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (cnt == 0) begin
          held_a = mem_addr_o; held_we = mem_we_o;
          if (mem_addr_o[5:0] != 0) proto_err++;
        end else if (held_a != mem_addr_o || held_we != mem_we_o) proto_err++;
        if (cnt == MEM_LAT) begin
          cnt = 0;
          base = int'(mem_addr_o) / 4;
          kind_hist = {kind_hist[0], mem_we_o};
          if (mem_we_o) begin
            for (int w = 0; w < 16; w++) mem_w[base + w] = mem_wdata_o[w*32 +: 32];
            n_wr++;
          end else begin
            for (int w = 0; w < 16; w++) mem_rdata_i[w*32 +: 32] = mem_w[base + w];
            n_rd++;
          end
          mem_ack_i = 1'b1;
        end else cnt++;
      end else if (cnt != 0) begin
        proto_err++;
        cnt = 0;
      end
    end
  end

  function automatic logic [ADDR_W-1:0] laddr(input int set, input int t, input int word);
    return ADDR_W'((t * SETS + set) * 64 + word * 4);
  endfunction

  task automatic do_op(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1'b1; req_op_i = op; req_addr_i = a; req_wdata_i = wd;
    @(negedge clk);
    req_valid_i = 1'b0;
    lat = 1;
    while (!resp_valid_o) begin
      if (req_ready_o) busy_err++;
      @(negedge clk);
      lat++;
    end
    rd = resp_rdata_o;
    @(negedge clk);
    if (resp_valid_o || !req_ready_o) busy_err++;
    if (op == 2'd1) ref_w[a / 4] = wd;
  endtask

  task automatic ld(input logic [ADDR_W-1:0] a, input string req);
    logic [31:0] rd; int lat;
    do_op(2'd0, a, '0, rd, lat);
    chk(rd == ref_w[a / 4], req, "load data", rd, ref_w[a / 4]);
  endtask

  task automatic st(input logic [ADDR_W-1:0] a, input logic [31:0] v);
    logic [31:0] rd; int lat;
    do_op(2'd1, a, v, rd, lat);
  endtask

  initial begin
    logic [31:0] rd;
    int lat, rd0, wr0, mism;
    for (int i = 0; i < NWORDS; i++) begin
      mem_w[i] = 32'h1357_9BDF ^ (i * 32'h9E37_79B1);
      ref_w[i] = mem_w[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1", "ready in reset", 32'(req_ready_o), 1);
    chk(resp_valid_o == 1'b0, "R1", "resp in reset", 32'(resp_valid_o), 0);
    chk(mem_req_o == 1'b0, "R1", "mem req in reset", 32'(mem_req_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready_o && !mem_req_o, "R1", "idle after reset", 32'(req_ready_o), 1);

    // R3: first load misses, one line read
    rd0 = n_rd; wr0 = n_wr;
    ld(laddr(0, 8, 5), "R3");
    chk(n_rd - rd0 == 1 && n_wr == wr0, "R3", "miss reads one line", n_rd - rd0, 1);

    // R2: hit on another word, fixed latency, no traffic
    rd0 = n_rd;
    do_op(2'd0, laddr(0, 8, 11), '0, rd, lat);
    chk(rd == ref_w[laddr(0, 8, 11) / 4], "R2", "hit data", rd, ref_w[laddr(0, 8, 11) / 4]);
    chk(lat == 2 + LAT, "R2", "hit latency", lat, 2 + LAT);
    chk(n_rd == rd0, "R2", "hit no traffic", n_rd - rd0, 0);

    // R4: store hit then read back
    do_op(2'd1, laddr(0, 8, 3), 32'hCAFE_0003, rd, lat);
    chk(lat == 2 + LAT, "R4", "store hit latency", lat, 2 + LAT);
    ld(laddr(0, 8, 3), "R4");

    // R5: LRU order in set 1
    for (int t = 8; t < 12; t++) ld(laddr(1, t, 0), "R5");
    ld(laddr(1, 8, 1), "R5");        // t8 becomes most recent, t9 oldest
    rd0 = n_rd; wr0 = n_wr;
    ld(laddr(1, 12, 0), "R5");       // evicts t9 (clean)
    chk(n_wr == wr0, "R6", "clean victim no write", n_wr - wr0, 0);
    ld(laddr(1, 8, 2), "R5");
    chk(n_rd - rd0 == 1, "R5", "recently used line kept", n_rd - rd0, 1);
    ld(laddr(1, 9, 2), "R5");
    chk(n_rd - rd0 == 2, "R5", "least recent line evicted", n_rd - rd0, 2);

    // R4/R6: dirty victim written back before fill
    st(laddr(2, 8, 7), 32'hD1D1_0707);
    for (int t = 9; t < 12; t++) ld(laddr(2, t, 0), "R4");
    rd0 = n_rd; wr0 = n_wr;
    ld(laddr(2, 12, 0), "R6");
    chk(n_wr - wr0 == 1, "R4", "eviction writes once", n_wr - wr0, 1);
    chk(kind_hist == 2'b10, "R6", "write before read", 32'(kind_hist), 2);
    chk(mem_w[laddr(2, 8, 7) / 4] == 32'hD1D1_0707, "R4", "memory holds store",
        mem_w[laddr(2, 8, 7) / 4], 32'hD1D1_0707);
    ld(laddr(2, 8, 7), "R4");

    // R7: flush dirty line
    st(laddr(3, 8, 0), 32'hF1F1_0000);
    wr0 = n_wr; rd0 = n_rd;
    do_op(2'd2, laddr(3, 8, 9), '0, rd, lat);
    chk(n_wr - wr0 == 1, "R7", "dirty flush writes", n_wr - wr0, 1);
    chk(mem_w[laddr(3, 8, 0) / 4] == 32'hF1F1_0000, "R7", "flushed data in memory",
        mem_w[laddr(3, 8, 0) / 4], 32'hF1F1_0000);
    ld(laddr(3, 8, 0), "R7");
    chk(n_rd - rd0 == 1, "R7", "access after flush misses", n_rd - rd0, 1);

    // R8: flush clean line
    ld(laddr(3, 9, 4), "R8");
    wr0 = n_wr; rd0 = n_rd;
    do_op(2'd2, laddr(3, 9, 4), '0, rd, lat);
    chk(lat == 2, "R8", "clean flush latency", lat, 2);
    chk(n_wr == wr0 && n_rd == rd0, "R8", "clean flush no traffic", n_wr - wr0, 0);
    ld(laddr(3, 9, 4), "R8");
    chk(n_rd - rd0 == 1, "R8", "line invalidated", n_rd - rd0, 1);

    // R9: flush miss
    wr0 = n_wr; rd0 = n_rd;
    do_op(2'd2, laddr(3, 20, 0), '0, rd, lat);
    chk(lat == 2, "R9", "flush miss latency", lat, 2);
    chk(n_wr == wr0 && n_rd == rd0, "R9", "flush miss no traffic", n_rd - rd0, 0);

    // sweep: more lines than ways in every set, every word
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++)
        for (int w = 0; w < 16; w++)
          st(laddr(s, t, w), 32'hA500_0000 ^ (32'(laddr(s, t, w)) * 32'h0100_0193));
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++)
        for (int w = 0; w < 16; w++) ld(laddr(s, t, w), "R4");
    for (int s = 0; s < SETS; s++)
      for (int t = 0; t < 6; t++) do_op(2'd2, laddr(s, t, 0), '0, rd, lat);
    mism = 0;
    for (int i = 0; i < NWORDS; i++) if (mem_w[i] != ref_w[i]) mism++;
    chk(mism == 0, "R7", "memory matches model after flush sweep", mism, 0);

    chk(busy_err == 0, "R10", "port busy and pulse rules", busy_err, 0);
    chk(proto_err == 0, "R11", "memory request held and aligned", proto_err, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual still busy expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule